// File: doc/BRIEF.md
# Write-Once Programming Tick Divider

This block turns a free-running input clock enable into the slow timing tick that paces a non-volatile program and erase engine. Software sets it up once after reset through a single 8-bit register. The register holds a 6-bit divide value and a select bit that places a fixed divide-by-8 prescaler ahead of the programmable divider. The tick period therefore follows the setting directly, and so does the run time of every program or erase step.

The setting can be changed only on the first write after reset. That first write also sets a read-only loaded flag, which comes out as `div_valid`. The command controller uses `div_valid` to reject array accesses made before the timing has been set up. Any write after the first has no effect. Until the register is loaded, the tick counters are held at zero and no tick is produced.

Top module: `ptg_tick_gen`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `div_valid` is 0 and `tick` is 0.
- R2: The first `reg_wr` after reset stores `reg_wdata[6]` as the prescaler select and `reg_wdata[5:0]` as the divide value. The value of `reg_wdata[7]` is discarded. From the next cycle on, `reg_rdata` reads `{1'b1, select, divide}` and `div_valid` is 1.
- R3: Every `reg_wr` after the first leaves the stored select and divide value unchanged, as seen on `reg_rdata`.
- R4: With select 0, `tick` pulses once every (1 + divide) cycles in which `clk_en` is high. The count starts with the first `clk_en` after loading.
- R5: With select 1, `tick` pulses once every 8 × (1 + divide) cycles in which `clk_en` is high.
- R6: `tick` is high for exactly one clock cycle. That cycle directly follows the clock edge on which the `clk_en` pulse that completes the period is sampled.
- R7: Before the register is loaded, `clk_en` has no effect: `tick` stays 0, and counting after loading starts from zero.
- R8: A cycle in which `clk_en` is low neither advances the count nor produces a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Input clock enable; each high cycle is one input clock period |
| reg_wr | input | 1 | Write strobe for the divider register |
| reg_wdata | input | 8 | Write data: [6] prescaler select, [5:0] divide value, [7] ignored |
| reg_rdata | output | 8 | Read data: [7] loaded, [6] select, [5:0] divide value |
| tick | output | 1 | Single-cycle timing tick |
| div_valid | output | 1 | High once the register has been loaded |

## Verification
The bench goes after the ends of the divide range. A divide value of 0 with no prescaler must give a tick on every enabled cycle; an off-by-one counter would instead halve the rate or skip ticks. The largest divide value with the prescaler on needs a 512-pulse period, which exposes a counter that wraps early or a prescaler left out of the path. Irregular `clk_en` patterns catch a design that counts clock cycles instead of enable pulses. Enables issued before loading, and writes with bit 7 set or issued after loading, catch a design that counts too early, stores the read-only bit, or lets later writes change the setting.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    // width of the programmable divide field
    localparam int DIV_W = 6;
    // width of the software-visible register: divide + select + loaded
    localparam int REG_W = DIV_W + 2;

    typedef struct packed {
        logic             pre_sel;
        logic [DIV_W-1:0] div;
    } ptg_cfg_t;

    // extract the writable part of a register write
    function automatic ptg_cfg_t cfg_from_wdata(input logic [REG_W-1:0] wdata);
        ptg_cfg_t c;
        c.pre_sel = wdata[DIV_W];
        c.div     = wdata[DIV_W-1:0];
        return c;
    endfunction

    // build the read view of the register
    function automatic logic [REG_W-1:0] rdata_from_cfg(input logic loaded, input ptg_cfg_t c);
        return {loaded, c.pre_sel, c.div};
    endfunction
endpackage

// File: rtl/ptg_cfg_reg.sv
module ptg_cfg_reg
    import ptg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ptg_cfg_t         cfg,
    output logic             loaded,
    output logic [REG_W-1:0] rd_data
);
    ptg_cfg_t cfg_q;
    logic     loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            loaded_q <= 1'b0;
        end else if (wr_en && !loaded_q) begin
            cfg_q    <= cfg_from_wdata(wr_data);
            loaded_q <= 1'b1;
        end
    end

    assign cfg     = cfg_q;
    assign loaded  = loaded_q;
    assign rd_data = rdata_from_cfg(loaded_q, cfg_q);

    // R2
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        loaded_q |=> loaded_q);
    // R3
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        loaded_q |=> $stable(cfg_q));
    // R2
    load_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !loaded_q) |=> (loaded_q && cfg_q == cfg_from_wdata($past(wr_data))));
endmodule

// File: rtl/ptg_prescale.sv
module ptg_prescale #(
    parameter int SHIFT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic en,
    input  logic pre_sel,
    output logic step
);
    generate
        if (SHIFT == 0) begin : g_bypass
            assign step = run && en;
        end else begin : g_div
            localparam int PCW = SHIFT;
            logic [PCW-1:0] pcnt;
            logic           wrap;

            assign wrap = (pcnt == {PCW{1'b1}});

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    pcnt <= '0;
                end else if (en && pre_sel) begin
                    pcnt <= pcnt + 1'b1;
                end
            end

            assign step = run && en && (!pre_sel || wrap);

            // R5
            pcnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
                (!pre_sel && !$past(pre_sel)) |-> (pcnt == '0));
        end
    endgenerate
endmodule

// File: rtl/ptg_div_count.sv
module ptg_div_count
    import ptg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt;
    logic             tick_q;
    logic             at_end;

    assign at_end = (dcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            dcnt   <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= step && at_end;
            if (step) begin
                dcnt <= at_end ? '0 : dcnt + 1'b1;
            end
        end
    end

    assign tick = tick_q;

    // R4
    dcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (dcnt <= div));
    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_q && div != '0) |=> !tick_q);
    // R8
    hold_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !step) |=> (!tick_q && $stable(dcnt)));
endmodule

// File: rtl/ptg_tick_gen.sv
module ptg_tick_gen
    import ptg_pkg::*;
#(
    parameter int PRE_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             tick,
    output logic             div_valid
);
    ptg_cfg_t cfg;
    logic     loaded;
    logic     step;

    ptg_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .cfg     (cfg),
        .loaded  (loaded),
        .rd_data (reg_rdata)
    );

    ptg_prescale #(.SHIFT(PRE_SHIFT)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (loaded),
        .en      (clk_en),
        .pre_sel (cfg.pre_sel),
        .step    (step)
    );

    ptg_div_count u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (loaded),
        .step (step),
        .div  (cfg.div),
        .tick (tick)
    );

    assign div_valid = loaded;

    // R7
    tick_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> div_valid);
    // R8
    tick_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> !tick);
endmodule

// File: tb/ptg_tick_gen_bench.sv
module ptg_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick;
    logic       div_valid;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    bit    cmp_on  = 0;
    string cur_req = "R1";

    // reference model state
    bit       m_loaded = 0;
    bit [6:0] m_cfg    = 0;
    longint   m_n      = 0;
    bit       m_tick   = 0;

    always #4 clk = ~clk;

    ptg_tick_gen u_ptg_tick_gen (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick      (tick),
        .div_valid (div_valid)
    );

    function automatic longint period();
        return longint'(m_cfg[5:0] + 1) * (m_cfg[6] ? 8 : 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_loaded = 0; m_cfg = 0; m_n = 0; m_tick = 0;
        end else begin
            m_tick = m_loaded && clk_en && (((m_n + 1) % period()) == 0);
            if (m_loaded && clk_en) m_n = m_n + 1;
            if (reg_wr && !m_loaded) begin
                m_loaded = 1;
                m_cfg    = reg_wdata[6:0];
            end
        end
    end

    task automatic check(input string req, input bit ok, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(cur_req, tick == m_tick, "tick", {7'd0, tick}, {7'd0, m_tick});
            check("R2", div_valid == m_loaded, "div_valid", {7'd0, div_valid}, {7'd0, m_loaded});
            check("R3", reg_rdata == {m_loaded, m_cfg}, "reg_rdata", reg_rdata, {m_loaded, m_cfg});
        end
    end

    task automatic do_reset();
        cmp_on = 0;
        @(negedge clk);
        rst = 1; reg_wr = 0; clk_en = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", reg_rdata == 8'h00, "reset rdata", reg_rdata, 8'h00);
        check("R1", div_valid == 1'b0, "reset valid", {7'd0, div_valid}, 8'h00);
        check("R1", tick == 1'b0, "reset tick", {7'd0, tick}, 8'h00);
        cmp_on = 1;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // mode 0: always on, 1: every third, 2: pseudo-random
    task automatic run_en(input int cycles, input int mode);
        for (int i = 0; i < cycles; i++) begin
            case (mode)
                0: clk_en = 1;
                1: clk_en = (i % 3 == 0);
                default: clk_en = $urandom_range(1, 0) == 1;
            endcase
            @(negedge clk);
        end
        clk_en = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: enables before load give no tick; R4 divide 0 every pulse
        do_reset();
        cur_req = "R7";
        run_en(20, 0);
        cur_req = "R4";
        wr(8'h00);
        run_en(40, 0);
        run_en(40, 2);

        // R2 bit 7 ignored; R3 later writes ignored; R4 divide 5, irregular enable (R8)
        do_reset();
        cur_req = "R8";
        wr(8'h85);
        wr(8'h3F);
        wr(8'h40);
        run_en(200, 1);
        run_en(200, 2);
        check("R3", reg_rdata == 8'h85, "after late writes", reg_rdata, 8'h85);

        // R5: prescaler with divide 2; R6 single pulse
        do_reset();
        cur_req = "R5";
        wr(8'h42);
        run_en(300, 0);
        cur_req = "R6";
        run_en(300, 2);

        // R5: largest divide with prescaler, write with bit 7 set
        do_reset();
        cur_req = "R5";
        wr(8'hFF);
        wr(8'h00);
        run_en(1600, 0);
        check("R2", reg_rdata == 8'hFF, "full-scale rdata", reg_rdata, 8'hFF);

        // R7: enable coincident with the loading write is not counted
        do_reset();
        cur_req = "R7";
        clk_en = 1;
        wr(8'h01);
        run_en(30, 0);

        cmp_on = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule